// File: doc/BRIEF.md
# Integer Execute Unit with Signed and Unsigned Set-on-Compare

This block is the purely combinational integer execution stage of a small 32-bit RISC pipeline. The block takes two register operands, a 16-bit immediate field from the instruction and a 5-bit operation code. From these it forms one 32-bit result and a flag that says whether the destination register should be written. It handles three kinds of operation: addition with wrap-around (signed and unsigned forms), bitwise AND, and a set-on-compare family that writes 1 or 0.

Every operation has a register-register form and an immediate form. The immediate is widened inside the block. The opcode decides how it is widened: signed operations replicate the immediate's top bit, while unsigned and logical operations fill with zeros. Each of the four compare relations is available with signed (two's-complement) ordering and with unsigned (magnitude) ordering.

The opcode layout is as follows. Bit 4 selects the immediate form. Bits 3..0 select the function:

| Code | Function |
|------|----------|
| 0 | add |
| 1 | add-unsigned |
| 2 | and |
| 4 | signed less-than |
| 5 | signed greater-than |
| 6 | signed less-or-equal |
| 7 | signed greater-or-equal |
| 12 | unsigned less-than |
| 13 | unsigned greater-than |
| 14 | unsigned less-or-equal |
| 15 | unsigned greater-or-equal |

Every other value of bits 3..0 is undefined.

Top module: `alu_int`

## Requirements
- R1: With op_i = 0x00, res_o equals a_i + b_i modulo 2^32, with no trap or flag on signed overflow (for example, 0x7FFFFFFF + 1 gives 0x80000000).
- R2: With op_i = 0x10, res_o equals a_i plus imm_i sign-extended, meaning imm_i[15] is copied into bits 31..16 of the second operand.
- R3: With op_i = 0x01, res_o equals a_i + b_i modulo 2^32. With op_i = 0x11, the second operand is imm_i zero-extended, with bits 31..16 equal to 0.
- R4: With op_i = 0x02, res_o is the bitwise AND of a_i and b_i. With op_i = 0x12, the second operand is imm_i zero-extended, so res_o[31:16] is always 0.
- R5: With op_i[4] = 0 and op_i[3:0] in 4..7, res_o is 32'h1 when a_i compared with b_i under two's-complement ordering satisfies the relation, and 32'h0 otherwise. The relations are: 4 less-than, 5 greater-than, 6 less-or-equal, 7 greater-or-equal.
- R6: With op_i[4] = 0 and op_i[3:0] in 12..15, res_o is 32'h1 or 32'h0 for the same four relations, in the same order, under unsigned magnitude ordering.
- R7: The immediate compare forms (op_i[4] = 1) compare a_i against imm_i. For codes 4..7 the immediate is sign-extended. For codes 12..15 it is zero-extended.
- R8: For any op_i whose bits 3..0 are not one of 0, 1, 2, 4..7 or 12..15, we_o is 0 and res_o is 0, whatever the other inputs are.
- R9: we_o is 1 for every defined opcode, in both the register and the immediate form.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First register operand |
| b_i | input | 32 | Second register operand (ignored in immediate forms) |
| imm_i | input | 16 | Immediate field from the instruction |
| op_i | input | 5 | Operation code; bit 4 selects the immediate form |
| res_o | output | 32 | Result |
| we_o | output | 1 | Destination write enable |

## Verification
Immediate widening and compare signedness are chosen by the same opcode, so one operation exercises both in a single evaluation. The bench provokes the case where they interact. It uses immediates with bit 15 set, such as 0x8000 and 0xFFFF, against small and negative a_i values. For these inputs the outcome of the compare flips depending on which extension was applied and which ordering was used. Each result is judged against a behavioural reference. That reference widens the immediate and orders the operands with the language's own signed and unsigned arithmetic. It is compared against the outputs on every clock, over directed corner cases and a pseudo-random sweep of all 32 opcodes.

// File: rtl/alu_int_pkg.sv
package alu_int_pkg;

  localparam int OP_W = 5;

  typedef enum logic [1:0] {
    SEL_ADD,
    SEL_AND,
    SEL_CMP,
    SEL_NONE
  } res_sel_e;

  typedef enum logic [1:0] {
    REL_LT,
    REL_GT,
    REL_LE,
    REL_GE
  } cmp_rel_e;

  typedef struct packed {
    logic     legal;
    logic     use_imm;
    logic     sext;
    logic     cmp_uns;
    res_sel_e sel;
    cmp_rel_e rel;
  } dec_t;

endpackage

// File: rtl/alu_int_dec.sv
module alu_int_dec
  import alu_int_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output dec_t            dec_o
);

  logic [3:0] fn;
  assign fn = op_i[3:0];

  always_comb begin
    dec_o         = '0;
    dec_o.sel     = SEL_NONE;
    dec_o.rel     = REL_LT;
    dec_o.use_imm = op_i[OP_W-1];
    unique case (fn)
      4'd0: begin dec_o.legal = 1'b1; dec_o.sel = SEL_ADD; dec_o.sext = 1'b1; end
      4'd1: begin dec_o.legal = 1'b1; dec_o.sel = SEL_ADD; end
      4'd2: begin dec_o.legal = 1'b1; dec_o.sel = SEL_AND; end
      4'd4, 4'd5, 4'd6, 4'd7: begin
        dec_o.legal = 1'b1;
        dec_o.sel   = SEL_CMP;
        dec_o.sext  = 1'b1;
        dec_o.rel   = cmp_rel_e'(fn[1:0]);
      end
      4'd12, 4'd13, 4'd14, 4'd15: begin
        dec_o.legal   = 1'b1;
        dec_o.sel     = SEL_CMP;
        dec_o.cmp_uns = 1'b1;
        dec_o.rel     = cmp_rel_e'(fn[1:0]);
      end
      default: dec_o.use_imm = 1'b0;
    endcase
  end

  // R8: undefined codes never select a result path
  always_comb begin
    if (!$isunknown(op_i)) begin
      p_illegal_none_r8: assert (dec_o.legal || dec_o.sel == SEL_NONE)
        else $error("undefined op selects a result path");
    end
  end

endmodule

// File: rtl/alu_int_opb.sv
module alu_int_opb #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  input  logic              sext_i,
  output logic [DATA_W-1:0] opb_o
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic             fill;
  logic [EXT_W-1:0] ext_hi;

  assign fill   = sext_i & imm_i[IMM_W-1];
  assign ext_hi = {EXT_W{fill}};
  assign opb_o  = use_imm_i ? {ext_hi, imm_i} : b_i;

endmodule

// File: rtl/alu_int_cmp.sv
module alu_int_cmp
  import alu_int_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              uns_i,
  input  cmp_rel_e          rel_i,
  output logic              flag_o
);

  logic [DATA_W:0] diff;
  logic            lt, eq;

  // widen by one bit: sign for signed, zero for unsigned; top of diff is the borrow
  assign diff = {~uns_i & a_i[DATA_W-1], a_i} - {~uns_i & b_i[DATA_W-1], b_i};
  assign lt   = diff[DATA_W];
  assign eq   = (a_i == b_i);

  always_comb begin
    unique case (rel_i)
      REL_LT:  flag_o = lt;
      REL_GT:  flag_o = ~lt & ~eq;
      REL_LE:  flag_o = lt | eq;
      default: flag_o = ~lt;
    endcase
  end

  // R5/R6: the borrow path and the equality path never disagree
  always_comb begin
    if (!$isunknown({a_i, b_i, uns_i})) begin
      p_lt_eq_excl_r6: assert (!(lt && eq))
        else $error("less-than and equal both set");
    end
  end

endmodule

// File: rtl/alu_int.sv
module alu_int
  import alu_int_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              we_o
);

  dec_t              dec;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] conj;
  logic              flag;

  alu_int_dec u_dec (
    .op_i  (op_i),
    .dec_o (dec)
  );

  alu_int_opb #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opb (
    .b_i       (b_i),
    .imm_i     (imm_i),
    .use_imm_i (dec.use_imm),
    .sext_i    (dec.sext),
    .opb_o     (opb)
  );

  alu_int_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a_i    (a_i),
    .b_i    (opb),
    .uns_i  (dec.cmp_uns),
    .rel_i  (dec.rel),
    .flag_o (flag)
  );

  assign sum  = a_i + opb;  // wraps, no overflow trap
  assign conj = a_i & opb;

  always_comb begin
    unique case (dec.sel)
      SEL_ADD: res_o = sum;
      SEL_AND: res_o = conj;
      SEL_CMP: res_o = {{(DATA_W-1){1'b0}}, flag};
      default: res_o = '0;
    endcase
  end

  assign we_o = dec.legal;

  always_comb begin
    if (!$isunknown({a_i, b_i, imm_i, op_i})) begin
      p_quiet_when_off_r8: assert (we_o || res_o == '0)
        else $error("result nonzero with write disabled");
      p_cmp_bool_r5: assert (!(we_o && op_i[2] && op_i[1:0] != 2'b11 && op_i[3:2] != 2'b10)
                             || res_o[DATA_W-1:1] == '0)
        else $error("compare result not 0/1");
      p_andi_hi_r4: assert (op_i != 5'h12 || res_o[DATA_W-1:IMM_W] == '0)
        else $error("and-immediate upper bits set");
      p_addui_zext_r3: assert (!(op_i == 5'h11 && a_i == '0) || res_o[DATA_W-1:IMM_W] == '0)
        else $error("add-unsigned immediate sign-extended");
      p_defined_we_r9: assert (!(op_i[3:0] == 4'd0 || op_i[3:0] == 4'd1 || op_i[3:0] == 4'd2) || we_o)
        else $error("defined arithmetic op without write");
    end
  end

endmodule

// File: tb/alu_int_bench.sv
module alu_int_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a, b, res;
  logic [15:0] imm;
  logic [4:0]  op;
  logic        we;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;

  always #5 clk = ~clk;

  alu_int u_alu_int (
    .a_i(a), .b_i(b), .imm_i(imm), .op_i(op), .res_o(res), .we_o(we)
  );

  function automatic logic [32:0] ref_model(logic [4:0] o, logic [31:0] x, logic [31:0] y,
                                            logic [15:0] k);
    logic [31:0] sx, zx, ob;
    logic        t;
    sx = {{16{k[15]}}, k};
    zx = {16'h0, k};
    case (o[3:0])
      4'd0: begin ob = o[4] ? sx : y; return {1'b1, x + ob}; end
      4'd1: begin ob = o[4] ? zx : y; return {1'b1, x + ob}; end
      4'd2: begin ob = o[4] ? zx : y; return {1'b1, x & ob}; end
      4'd4, 4'd5, 4'd6, 4'd7: begin
        ob = o[4] ? sx : y;
        case (o[1:0])
          2'd0: t = $signed(x) <  $signed(ob);
          2'd1: t = $signed(x) >  $signed(ob);
          2'd2: t = $signed(x) <= $signed(ob);
          default: t = $signed(x) >= $signed(ob);
        endcase
        return {1'b1, 31'h0, t};
      end
      4'd12, 4'd13, 4'd14, 4'd15: begin
        ob = o[4] ? zx : y;
        case (o[1:0])
          2'd0: t = x <  ob;
          2'd1: t = x >  ob;
          2'd2: t = x <= ob;
          default: t = x >= ob;
        endcase
        return {1'b1, 31'h0, t};
      end
      default: return 33'h0;
    endcase
  endfunction

  function automatic string req_of(logic [4:0] o);
    case (o[3:0])
      4'd0: return o[4] ? "R2" : "R1";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd4, 4'd5, 4'd6, 4'd7: return o[4] ? "R7" : "R5";
      4'd12, 4'd13, 4'd14, 4'd15: return o[4] ? "R7" : "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic run(logic [4:0] o, logic [31:0] x, logic [31:0] y, logic [15:0] k);
    logic [32:0] exp;
    @(posedge clk);
    op = o; a = x; b = y; imm = k;
    @(negedge clk);
    exp = ref_model(o, x, y, k);
    checks++;
    if (res !== exp[31:0]) begin
      fails++;
      $display("FAIL %s op=%h a=%h b=%h imm=%h res actual=%h expected=%h",
               req_of(o), o, x, y, k, res, exp[31:0]);
    end
    checks++;
    if (we !== exp[32]) begin
      fails++;
      $display("FAIL %s we op=%h actual=%b expected=%b",
               exp[32] ? "R9" : "R8", o, we, exp[32]);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    op = 5'h0; a = '0; b = '0; imm = '0;
    // reset state: zero inputs give add of zeros (R1)
    @(negedge clk);
    checks++;
    if (res !== 32'h0 || we !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset res actual=%h expected=%h", res, 32'h0);
    end
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    run(5'h00, 32'h7FFF_FFFF, 32'h1, 16'h0);        // R1 wrap
    run(5'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0); // R1
    run(5'h10, 32'h0000_0010, 32'h0, 16'h8000);      // R2 sign extension
    run(5'h10, 32'h1234_0000, 32'hDEAD, 16'hFFFF);   // R2, b ignored
    run(5'h11, 32'h0000_0010, 32'h0, 16'h8000);      // R3 zero extension
    run(5'h01, 32'h8000_0000, 32'h8000_0000, 16'h0); // R3 wrap
    run(5'h02, 32'hF0F0_A5A5, 32'h0FF0_FFFF, 16'h0); // R4
    run(5'h12, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hC3C3); // R4 upper zero
    run(5'h04, 32'hFFFF_FFFF, 32'h1, 16'h0);         // R5 -1 < 1
    run(5'h0C, 32'hFFFF_FFFF, 32'h1, 16'h0);         // R6 big > 1
    run(5'h07, 32'h5, 32'h5, 16'h0);                 // R5 ge equal
    run(5'h0E, 32'h5, 32'h5, 16'h0);                 // R6 le equal
    run(5'h0F, 32'h0, 32'hFFFF_FFFF, 16'h0);         // R6
    run(5'h05, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0); // R5 extremes
    run(5'h14, 32'h0, 32'h0, 16'hFFFF);              // R7 signed: 0 < -1 false
    run(5'h1C, 32'h0, 32'h0, 16'hFFFF);              // R7 unsigned: 0 < 65535 true
    run(5'h1D, 32'hFFFF_8000, 32'h0, 16'h8000);      // R7 unsigned gt
    run(5'h16, 32'hFFFF_8000, 32'h0, 16'h8000);      // R7 signed le equal
    run(5'h03, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF); // R8
    run(5'h08, 32'h1, 32'h2, 16'h3);                 // R8
    run(5'h1B, 32'h1, 32'h2, 16'h3);                 // R8
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = (i % 4 == 0) ? ra : $urandom;
      if (i % 7 == 0) ra = {ra[31], 15'h0, ra[15:0]};
      run(5'(i % 32), ra, rb, 16'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule